// File: doc/BRIEF.md
# Load-Store Issue Interlock

This block sits at the issue point of an in-order pipeline and decides, every cycle, whether the candidate instruction presented to it may leave. A load that misses the data cache does not block the pipe: its destination register tag goes into a small in-order queue of outstanding bus reads, and only instructions that name a pending register as a source are held back. A load that hits the cache costs a single bubble, and only when the next instruction reads its result. Stores are treated conservatively. Any store waits until the outstanding-read queue is empty, whether or not it shares a register with those loads. This ensures that fill data from an older read miss can never land on a line that a younger store has already written.

The memory side signals each returning read with a one-cycle completion strobe. Returns arrive in the order the reads were issued. The block answers with a pop strobe, and it raises a push strobe carrying the destination tag whenever a missing load issues.

The block is built from three state machines. The queue occupancy machine has the states OCC_EMPTY, OCC_PART and OCC_FULL. Its transitions come from the next-cycle count: reaching zero goes to OCC_EMPTY, reaching the depth goes to OCC_FULL, and any other value goes to OCC_PART. The hit-window machine has the states HW_IDLE and HW_ARMED. A cache-hit load issuing moves it to HW_ARMED, and every other cycle returns it to HW_IDLE. The per-cycle issue decision is ISS_NONE, ISS_GO, ISS_DEP, ISS_FULL or ISS_ORDER, checked in that priority from ISS_DEP down. All three reset to OCC_EMPTY, HW_IDLE and ISS_NONE.

Top module: `ldg_issue_gate`

## Requirements
- R1: An instruction whose sources match no pending tag issues (stall low) while miss loads are outstanding.
- R2: When a cache-hit load issues (cand_kind 2'b01, dc_hit high), an instruction in the next cycle with a source equal to its destination stalls for exactly one cycle and issues in the cycle after.
- R3: An instruction with a source equal to the tag of a queued miss load stalls until that entry's completion. It issues in the cycle after the completion strobe.
- R4: Loads that miss issue on consecutive cycles without stalling until DEPTH (default 4) are outstanding. A load then stalls while the queue is full and no completion arrives in the same cycle.
- R5: A store (cand_kind 2'b10) stalls while any miss load is outstanding, even with no register overlap. It issues in the cycle after the queue drains.
- R6: A load presented while the queue is full issues in a cycle with a completion, and reuses the freed slot.
- R7: Completions retire entries oldest first. A completion strobe with an empty queue produces no pop.
- R8: A non-memory instruction (cand_kind 2'b00 or 2'b11) with no pending dependency never stalls, also when the queue is full.
- R9: A miss load raises q_push_o with its destination as q_push_tag_o. A hit load, or a stalled load, raises no push.
- R10: After reset the queue and hit window are empty: stall_o is low and a store or former dependant issues at once.
- R11: With cand_valid_i low, stall_o and q_push_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_valid_i | input | 1 | Candidate instruction present |
| cand_kind_i | input | 2 | 00 other, 01 load, 10 store, 11 other |
| cand_src_a_i | input | 5 | First source register |
| cand_src_b_i | input | 5 | Second source register |
| cand_dst_i | input | 5 | Destination register of a load |
| dc_hit_i | input | 1 | Cache lookup of the candidate load hit |
| ret_valid_i | input | 1 | Oldest outstanding read has returned |
| stall_o | output | 1 | Hold the candidate this cycle |
| q_push_o | output | 1 | Miss load enters the bus read queue |
| q_push_tag_o | output | 5 | Destination tag of the pushed load |
| q_pop_o | output | 1 | Oldest queue entry retires |

## Verification
The assertions take for granted that completion strobes never outnumber the pushed loads, and that the hit flag is meaningful only for a load. The stimulus keeps the first condition by raising completions only while it knows entries remain, with one deliberate strobe on an empty queue to show it is discarded. Stalled instructions are held unchanged by the stimulus on the following cycle, as the pipeline would hold them, so the release cycle of each dependency can be observed.

// File: rtl/ldg_pkg.sv
package ldg_pkg;

    typedef enum logic [1:0] {
        OP_OTHER = 2'b00,
        OP_LOAD  = 2'b01,
        OP_STORE = 2'b10,
        OP_MISC  = 2'b11
    } op_kind_e;

    typedef enum logic [1:0] {
        OCC_EMPTY,
        OCC_PART,
        OCC_FULL
    } occ_state_e;

    typedef enum logic {
        HW_IDLE,
        HW_ARMED
    } hitwin_state_e;

    typedef enum logic [2:0] {
        ISS_NONE,
        ISS_GO,
        ISS_DEP,
        ISS_FULL,
        ISS_ORDER
    } issue_e;

endpackage

// File: rtl/ldg_pend_queue.sv
module ldg_pend_queue
    import ldg_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int TAG_W = 5,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [TAG_W-1:0] push_tag_i,
    input  logic             pop_i,
    input  logic [TAG_W-1:0] src_a_i,
    input  logic [TAG_W-1:0] src_b_i,
    output logic             match_o,
    output logic             empty_o,
    output logic             full_o,
    output logic [CNT_W-1:0] count_o
);

    logic [DEPTH-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [PTR_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] count_q, count_nxt;
    occ_state_e       occ_q, occ_nxt;
    logic [DEPTH-1:0] hit_vec;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Per-entry source compare
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cmp
        assign hit_vec[gi] = valid_q[gi] &&
                             ((tag_q[gi] == src_a_i) || (tag_q[gi] == src_b_i));
    end
    assign match_o = |hit_vec;

    // Next occupancy state
    always_comb begin
        count_nxt = count_q + CNT_W'(push_i) - CNT_W'(pop_i);
        if (count_nxt == '0)
            occ_nxt = OCC_EMPTY;
        else if (count_nxt == CNT_W'(DEPTH))
            occ_nxt = OCC_FULL;
        else
            occ_nxt = OCC_PART;
    end

    // State register and entry storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
            occ_q   <= OCC_EMPTY;
            for (int i = 0; i < DEPTH; i++) tag_q[i] <= '0;
        end else begin
            if (pop_i) begin
                valid_q[head_q] <= 1'b0;
                head_q          <= ptr_inc(head_q);
            end
            if (push_i) begin
                valid_q[tail_q] <= 1'b1;
                tag_q[tail_q]   <= push_tag_i;
                tail_q          <= ptr_inc(tail_q);
            end
            count_q <= count_nxt;
            occ_q   <= occ_nxt;
        end
    end

    // Outputs decoded from state
    always_comb begin
        empty_o = 1'b0;
        full_o  = 1'b0;
        unique case (occ_q)
            OCC_EMPTY: empty_o = 1'b1;
            OCC_PART:  ;
            OCC_FULL:  full_o  = 1'b1;
            default:   ;
        endcase
    end
    assign count_o = count_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o) |-> pop_i); // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o); // R7
    AST_COUNT_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |=> (count_o == $past(count_o) + 1'b1)); // R4

endmodule

// File: rtl/ldg_hit_window.sv
module ldg_hit_window
    import ldg_pkg::*;
#(
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic [TAG_W-1:0] arm_tag_i,
    input  logic [TAG_W-1:0] src_a_i,
    input  logic [TAG_W-1:0] src_b_i,
    output logic             dep_o
);

    hitwin_state_e    st_q, st_nxt;
    logic [TAG_W-1:0] tag_q;

    always_comb st_nxt = arm_i ? HW_ARMED : HW_IDLE;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= HW_IDLE;
            tag_q <= '0;
        end else begin
            st_q <= st_nxt;
            if (arm_i) tag_q <= arm_tag_i;
        end
    end

    always_comb begin
        dep_o = 1'b0;
        unique case (st_q)
            HW_IDLE:  dep_o = 1'b0;
            HW_ARMED: dep_o = (tag_q == src_a_i) || (tag_q == src_b_i);
            default:  dep_o = 1'b0;
        endcase
    end

    AST_BUBBLE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == HW_ARMED && !arm_i) |=> !dep_o); // R2

endmodule

// File: rtl/ldg_issue_gate.sv
module ldg_issue_gate
    import ldg_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int TAG_W = 5,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cand_valid_i,
    input  logic [1:0]       cand_kind_i,
    input  logic [TAG_W-1:0] cand_src_a_i,
    input  logic [TAG_W-1:0] cand_src_b_i,
    input  logic [TAG_W-1:0] cand_dst_i,
    input  logic             dc_hit_i,
    input  logic             ret_valid_i,
    output logic             stall_o,
    output logic             q_push_o,
    output logic [TAG_W-1:0] q_push_tag_o,
    output logic             q_pop_o
);

    op_kind_e   kind;
    issue_e     decision;
    logic       is_load, is_store;
    logic       q_match, q_empty, q_full, hw_dep, dep_any;
    logic       issue_go;
    logic [CNT_W-1:0] q_count;

    assign kind     = op_kind_e'(cand_kind_i);
    assign is_load  = (kind == OP_LOAD);
    assign is_store = (kind == OP_STORE);
    assign q_pop_o  = ret_valid_i && !q_empty;
    assign dep_any  = q_match || hw_dep;

    // Issue decision, priority: dependency, full queue, store order
    always_comb begin
        if (!cand_valid_i)
            decision = ISS_NONE;
        else if (dep_any)
            decision = ISS_DEP;
        else if (is_load && q_full && !q_pop_o)
            decision = ISS_FULL;
        else if (is_store && !q_empty)
            decision = ISS_ORDER;
        else
            decision = ISS_GO;
    end

    always_comb begin
        stall_o  = 1'b0;
        issue_go = 1'b0;
        unique case (decision)
            ISS_NONE:  ;
            ISS_GO:    issue_go = 1'b1;
            ISS_DEP:   stall_o  = 1'b1;
            ISS_FULL:  stall_o  = 1'b1;
            ISS_ORDER: stall_o  = 1'b1;
            default:   ;
        endcase
    end

    assign q_push_o     = issue_go && is_load && !dc_hit_i;
    assign q_push_tag_o = cand_dst_i;

    ldg_pend_queue #(
        .DEPTH (DEPTH),
        .TAG_W (TAG_W)
    ) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (q_push_o),
        .push_tag_i (cand_dst_i),
        .pop_i      (q_pop_o),
        .src_a_i    (cand_src_a_i),
        .src_b_i    (cand_src_b_i),
        .match_o    (q_match),
        .empty_o    (q_empty),
        .full_o     (q_full),
        .count_o    (q_count)
    );

    ldg_hit_window #(
        .TAG_W (TAG_W)
    ) u_hitwin (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (issue_go && is_load && dc_hit_i),
        .arm_tag_i (cand_dst_i),
        .src_a_i   (cand_src_a_i),
        .src_b_i   (cand_src_b_i),
        .dep_o     (hw_dep)
    );

    AST_STORE_BEHIND_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid_i && is_store && !stall_o) |-> (q_count == '0)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cand_valid_i |-> (!stall_o && !q_push_o)); // R11
    AST_FREE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid_i && !is_load && !is_store && !q_match && !hw_dep) |-> !stall_o); // R8

endmodule

// File: tb/ldg_issue_gate_tb_top.sv
`timescale 1ns/1ps
module ldg_issue_gate_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cv;
    logic [1:0] ck;
    logic [4:0] sa, sb, sd;
    logic       hit, ret;
    logic       stall, push, pop;
    logic [4:0] ptag;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    ldg_issue_gate dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cand_valid_i (cv),
        .cand_kind_i  (ck),
        .cand_src_a_i (sa),
        .cand_src_b_i (sb),
        .cand_dst_i   (sd),
        .dc_hit_i     (hit),
        .ret_valid_i  (ret),
        .stall_o      (stall),
        .q_push_o     (push),
        .q_push_tag_o (ptag),
        .q_pop_o      (pop)
    );

    typedef struct packed {
        logic       v;
        logic [1:0] k;
        logic [4:0] a;
        logic [4:0] b;
        logic [4:0] d;
        logic       h;
        logic       r;
        logic       e_st;
        logic       e_pu;
        logic       e_po;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 26;
    // kind: 0 other, 1 load, 2 store
    localparam vec_t TBL [NV] = '{
        '{1'b0, 2'd0, 5'd0,  5'd0, 5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd11}, // R11 idle
        '{1'b1, 2'd1, 5'd1,  5'd2, 5'd5,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd9},  // R9 miss push 5
        '{1'b1, 2'd0, 5'd3,  5'd4, 5'd1,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1},  // R1 independent
        '{1'b1, 2'd0, 5'd5,  5'd4, 5'd1,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 reads r5
        '{1'b1, 2'd0, 5'd4,  5'd5, 5'd1,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 still waiting
        '{1'b1, 2'd1, 5'd1,  5'd1, 5'd6,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 back-to-back
        '{1'b1, 2'd1, 5'd2,  5'd2, 5'd7,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd4},
        '{1'b1, 2'd1, 5'd3,  5'd3, 5'd8,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd4},  // queue now full
        '{1'b1, 2'd1, 5'd1,  5'd2, 5'd9,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 full stall
        '{1'b1, 2'd0, 5'd2,  5'd3, 5'd4,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 full, no stall
        '{1'b1, 2'd2, 5'd1,  5'd2, 5'd0,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 store waits
        '{1'b1, 2'd1, 5'd1,  5'd2, 5'd9,  1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd6},  // R6 reuse slot
        '{1'b1, 2'd0, 5'd5,  5'd3, 5'd1,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 r5 released
        '{1'b0, 2'd0, 5'd6,  5'd6, 5'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd11}, // R11 invalid, pop r6
        '{1'b1, 2'd0, 5'd7,  5'd1, 5'd1,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd7},  // R7 r7 pops now
        '{1'b1, 2'd0, 5'd7,  5'd8, 5'd1,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 r8 still pending
        '{1'b1, 2'd2, 5'd0,  5'd0, 5'd0,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd5},
        '{1'b1, 2'd2, 5'd0,  5'd0, 5'd0,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd5},  // last entry leaves
        '{1'b1, 2'd2, 5'd0,  5'd0, 5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 drained
        '{1'b1, 2'd1, 5'd1,  5'd2, 5'd10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},  // hit, no push
        '{1'b1, 2'd0, 5'd4,  5'd10,5'd1,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 bubble
        '{1'b1, 2'd0, 5'd4,  5'd10,5'd1,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 one cycle only
        '{1'b1, 2'd1, 5'd1,  5'd2, 5'd11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},
        '{1'b1, 2'd0, 5'd3,  5'd4, 5'd1,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1},  // no reader, no bubble
        '{1'b1, 2'd0, 5'd11, 5'd3, 5'd1,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // window expired
        '{1'b0, 2'd0, 5'd0,  5'd0, 5'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7}   // R7 empty, no pop
    };

    task automatic check(input string what, input int req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] k, input logic [4:0] a, input logic [4:0] b,
                         input logic [4:0] d, input logic h, input logic r);
        cv = v; ck = k; sa = a; sb = b; sd = d; hit = h; ret = r;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        #1;
        check("stall in reset", 10, {4'd0, stall}, 5'd0); // R10
        check("pop in reset", 10, {4'd0, pop}, 5'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(TBL[i].v, TBL[i].k, TBL[i].a, TBL[i].b, TBL[i].d, TBL[i].h, TBL[i].r);
            #1;
            check($sformatf("row %0d stall", i), int'(TBL[i].req), {4'd0, stall}, {4'd0, TBL[i].e_st});
            check($sformatf("row %0d push", i), int'(TBL[i].req), {4'd0, push}, {4'd0, TBL[i].e_pu});
            check($sformatf("row %0d pop", i), int'(TBL[i].req), {4'd0, pop}, {4'd0, TBL[i].e_po});
            if (TBL[i].e_pu)
                check($sformatf("row %0d push tag", i), 9, ptag, TBL[i].d);
        end

        // R10: reset with loads outstanding clears all pending state
        @(negedge clk); drive(1'b1, 2'd1, 5'd1, 5'd2, 5'd20, 1'b0, 1'b0);
        @(negedge clk); drive(1'b1, 2'd1, 5'd1, 5'd2, 5'd21, 1'b0, 1'b0);
        @(negedge clk); drive(1'b1, 2'd2, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0);
        #1 check("store behind two misses", 5, {4'd0, stall}, 5'd1);
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 2'd2, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0);
        #1 check("store after reset", 10, {4'd0, stall}, 5'd0); // R10
        @(negedge clk); drive(1'b1, 2'd0, 5'd20, 5'd21, 5'd1, 1'b0, 1'b0);
        #1 check("old dependant after reset", 10, {4'd0, stall}, 5'd0);

        // R2: hit bubble with the load's tag on the second source
        @(negedge clk); drive(1'b1, 2'd1, 5'd3, 5'd3, 5'd12, 1'b1, 1'b0);
        @(negedge clk); drive(1'b1, 2'd2, 5'd12, 5'd12, 5'd0, 1'b0, 1'b0);
        #1 check("store reads hit dst", 2, {4'd0, stall}, 5'd1);
        @(negedge clk);
        #1 check("store after bubble", 2, {4'd0, stall}, 5'd0);

        @(negedge clk); drive(1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule